// File: doc/BRIEF.md
# Redundant Non-Binary Successive-Approximation Controller

This block is the digital sequencer of a successive-approximation converter that resolves an N-bit code in M comparison steps, with M larger than N. The step sizes are not a halving series. They come from a design-time table of M-1 weights, one per step after the first. The extra steps give overlap between the search windows, so a wrong comparator decision early in the conversion is absorbed by the later steps. No correction hardware is needed for this. A different search algorithm is obtained by editing the table and nothing else.

A start pulse loads the mid-scale reference. In every step the block leaves one settle cycle for the external DAC. It then raises a request and waits for a comparator decision. A decision of "above" adds the next table weight to the reference, and "below" subtracts it. The reference is kept in half-LSB units, so the final plus or minus half-LSB term is exact. After the M-th decision the block applies that term, clamps the result to the N-bit range and pulses done. The DAC, the comparator and the sample-and-hold are outside the block.

Top module: `sar_redund_ctrl`

## Requirements
- R1: While reset is held low, busy, cmp_req and done are 0, result is 0 and dac_code equals mid-scale 2^(N-1) (8 for the default N=4).
- R2: A start pulse while idle makes busy 1 in the next cycle, with cmp_req still 0 and dac_code at mid-scale. The step-1 request follows one cycle later.
- R3: In every step, cmp_req rises after one settle cycle and stays high with dac_code unchanged until cmp_valid arrives. cmp_valid while cmp_req is low is ignored and leaves dac_code unchanged.
- R4: After the decision of step k (k < M), dac_code moves by the table weight of step k+1: it goes up when cmp_above was 1 and down when it was 0. Default weights for steps 2..5 are 3, 2, 1, 1.
- R5: Exactly M decisions are taken. done is a one-cycle pulse in the cycle after the M-th decision, busy is 0 in that cycle, and done never rises earlier.
- R6: result equals mid-scale plus the signed sum of the weights applied, minus 1 when the last decision is "below". It is clamped to 0..2^N-1. With the default table, the decision sequences 1,0,1,0,1 and 0,1,1,1,1 (step 1 first) both give 9. All-above gives 15 and all-below gives 0.
- R7: For any input between codes, result equals the floor of the input. This holds even when any step's decision is wrong, provided the input lies within that step's tolerance of the reference. The tolerance is the sum of the weights after step k+1, plus 1, minus the weight of step k+1.
- R8: A start pulse during a conversion is ignored, and the conversion completes with its normal result.
- R9: result holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (single-cycle pulse) |
| cmp_req | output | 1 | Asks for a comparator decision on the current reference |
| cmp_valid | input | 1 | Decision present on cmp_above this cycle |
| cmp_above | input | 1 | 1: input above reference, 0: below |
| dac_code | output | N+3 | Signed reference code for the DAC, in LSB units |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | N | Corrected, clamped conversion result |

## Verification
Every response is due a fixed number of cycles after its cause. A start pulse shows mid-scale with busy one edge later, and the first request follows one edge after that. A decision accepted at an edge moves dac_code and drops cmp_req at that same edge, and after the last decision result and done appear at that edge. The bench drives inputs and samples outputs on falling edges. It checks each of these values exactly one falling edge after the stimulus, and it checks the reference against the bench's own weight table before every decision.

// File: rtl/sar_redund_pkg.sv
package sar_redund_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_DECIDE
    } sar_state_e;

endpackage

// File: rtl/sar_step_rom.sv
// Weight table lookup: entry i holds the weight applied after decision i+1.
module sar_step_rom #(
    parameter int STEP_W  = 4,
    parameter int NUM_ENT = 4,
    parameter int IW      = 3,
    parameter logic [NUM_ENT*STEP_W-1:0] TABLE = '0
) (
    input  logic [IW-1:0]     idx,
    output logic [STEP_W-1:0] step_size
);

    logic [STEP_W-1:0] ent [NUM_ENT];

    for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_ent
        assign ent[gi] = TABLE[gi*STEP_W +: STEP_W];
    end

    always_comb begin
        step_size = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (idx == IW'(i)) begin
                step_size = ent[i];
            end
        end
    end

endmodule

// File: rtl/sar_ref_step.sv
// Reference update in half-LSB units: add or subtract twice the weight.
module sar_ref_step #(
    parameter int RW     = 8,
    parameter int STEP_W = 4
) (
    input  logic signed [RW-1:0] ref_h,
    input  logic [STEP_W-1:0]    step_size,
    input  logic                 up,
    output logic signed [RW-1:0] ref_nxt
);

    logic signed [RW-1:0] delta_h;

    assign delta_h = signed'({{(RW-STEP_W-1){1'b0}}, step_size, 1'b0});
    assign ref_nxt = up ? (ref_h + delta_h) : (ref_h - delta_h);

endmodule

// File: rtl/sar_result_fix.sv
// Final half-LSB term, floor to whole LSB, clamp to the N-bit range.
module sar_result_fix #(
    parameter int N  = 4,
    parameter int RW = 8
) (
    input  logic signed [RW-1:0] ref_h,
    input  logic                 last_above,
    output logic [N-1:0]         code
);

    localparam logic signed [RW-1:0] ONE_H  = 1;
    localparam logic signed [RW-1:0] ZERO_H = 0;
    localparam logic signed [RW-1:0] TOP    = (1 << N) - 1;

    logic signed [RW-1:0] sum_h;
    logic signed [RW-1:0] whole;

    always_comb begin
        sum_h = last_above ? (ref_h + ONE_H) : (ref_h - ONE_H);
        whole = sum_h >>> 1;
        if (whole < ZERO_H) begin
            code = '0;
        end else if (whole > TOP) begin
            code = '1;
        end else begin
            code = whole[N-1:0];
        end
    end

endmodule

// File: rtl/sar_redund_ctrl.sv
module sar_redund_ctrl
    import sar_redund_pkg::*;
#(
    parameter int N      = 4,
    parameter int M      = 5,
    parameter int STEP_W = 4,
    parameter logic [(M-1)*STEP_W-1:0] STEP_TABLE = {4'd1, 4'd1, 4'd2, 4'd3}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                cmp_req,
    input  logic                cmp_valid,
    input  logic                cmp_above,
    output logic signed [N+2:0] dac_code,
    output logic                busy,
    output logic                done,
    output logic [N-1:0]        result
);

    localparam int CW = $clog2(M + 1);
    localparam int RW = N + 4;
    localparam logic signed [RW-1:0] MID_H = 2 ** N;
    localparam logic [CW-1:0] LAST_STEP = CW'(M);

    typedef struct packed {
        sar_state_e           state;
        logic [CW-1:0]        step;
        logic signed [RW-1:0] ref_h;
        logic                 done;
        logic [N-1:0]         result;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [CW-1:0]        rom_idx;
    logic [STEP_W-1:0]    step_size;
    logic signed [RW-1:0] ref_nxt;
    logic [N-1:0]         fixed_code;

    assign rom_idx = s_q.step - 1'b1;

    sar_step_rom #(
        .STEP_W (STEP_W),
        .NUM_ENT(M - 1),
        .IW     (CW),
        .TABLE  (STEP_TABLE)
    ) rom_i (
        .idx      (rom_idx),
        .step_size(step_size)
    );

    sar_ref_step #(
        .RW    (RW),
        .STEP_W(STEP_W)
    ) upd_i (
        .ref_h    (s_q.ref_h),
        .step_size(step_size),
        .up       (cmp_above),
        .ref_nxt  (ref_nxt)
    );

    sar_result_fix #(
        .N (N),
        .RW(RW)
    ) fix_i (
        .ref_h     (s_q.ref_h),
        .last_above(cmp_above),
        .code      (fixed_code)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.state = ST_SETTLE;
                    s_d.step  = CW'(1);
                    s_d.ref_h = MID_H;
                end
            end
            ST_SETTLE: begin
                s_d.state = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (cmp_valid) begin
                    if (s_q.step == LAST_STEP) begin
                        s_d.state  = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.result = fixed_code;
                    end else begin
                        s_d.state = ST_SETTLE;
                        s_d.step  = s_q.step + 1'b1;
                        s_d.ref_h = ref_nxt;
                    end
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state  <= ST_IDLE;
            s_q.step   <= '0;
            s_q.ref_h  <= MID_H;
            s_q.done   <= 1'b0;
            s_q.result <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmp_req  = (s_q.state == ST_DECIDE);
    assign busy     = (s_q.state != ST_IDLE);
    assign done     = s_q.done;
    assign result   = s_q.result;
    assign dac_code = s_q.ref_h[RW-1:1];

endmodule

// File: rtl/sar_redund_chk.sv
module sar_redund_chk #(
    parameter int N  = 4,
    parameter int DW = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 cmp_req,
    input logic                 cmp_valid,
    input logic                 cmp_above,
    input logic signed [DW-1:0] dac_code,
    input logic                 busy,
    input logic                 done,
    input logic [N-1:0]         result
);

    localparam logic signed [DW-1:0] MID = 2 ** (N - 1);

    assert_start_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !cmp_req && dac_code == MID));

    assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req |-> busy);

    assert_dac_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && !cmp_valid) |=> (cmp_req && $stable(dac_code)));

    assert_settle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cmp_valid) |=> !cmp_req);

    assert_rise_on_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cmp_valid && cmp_above) |=> (done || dac_code > $past(dac_code)));

    assert_fall_on_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cmp_valid && !cmp_above) |=> (done || dac_code < $past(dac_code)));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_decision_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(cmp_req && cmp_valid)));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !cmp_req) |=> cmp_req);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind sar_redund_ctrl sar_redund_chk #(
    .N (N),
    .DW(N + 3)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmp_req  (cmp_req),
    .cmp_valid(cmp_valid),
    .cmp_above(cmp_above),
    .dac_code (dac_code),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/sar_redund_ctrl_tb_top.sv
module sar_redund_ctrl_tb_top;

    localparam int N   = 4;
    localparam int M   = 5;
    localparam int MID = 8;
    localparam int BW [4] = '{3, 2, 1, 1};   // weights of steps 2..5

    // {decisions step1..step5 (step1 in MSB), expected result}
    localparam logic [8:0] VEC [6] = '{
        {5'b10101, 4'd9},
        {5'b01111, 4'd9},
        {5'b11111, 4'd15},
        {5'b00000, 4'd0},
        {5'b10000, 4'd6},
        {5'b01000, 4'd4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              cmp_valid = 1'b0;
    logic              cmp_above = 1'b0;
    logic              cmp_req;
    logic signed [6:0] dac_code;
    logic              busy;
    logic              done;
    logic [N-1:0]      result;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sar_redund_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_req  (cmp_req),
        .cmp_valid(cmp_valid),
        .cmp_above(cmp_above),
        .dac_code (dac_code),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    function automatic int wgt(input int k);
        return BW[k-2];
    endfunction

    function automatic int tol(input int k);
        int s = 0;
        if (k >= M) return 0;
        for (int j = k + 2; j <= M; j++) s += wgt(j);
        return s + 1 - wgt(k + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic wait_req();
        int g = 0;
        while (!cmp_req && g < 50) begin
            @(negedge clk);
            g++;
        end
    endtask

    // mode 0: decisions from pat; mode 1: comparator model on vin2 (half-LSB units)
    // poke 1: stray cmp_valid in a settle cycle; poke 2: start during conversion
    task automatic run_conv(input int mode, input logic [M-1:0] pat, input int vin2,
                            input bit inject, input int poke, output int res);
        int  prev = 0;
        bit  prevd = 1'b0;
        bit  d;
        int  diff;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !cmp_req && dac_code == MID, "R2", int'(dac_code), MID, "start response");
        for (int k = 1; k <= M; k++) begin
            wait_req();
            chk(cmp_req, "R3", int'(cmp_req), 1, "request raised");
            if (k == 1)
                chk(dac_code == MID, "R2", int'(dac_code), MID, "first reference");
            else
                chk(int'(dac_code) == prev + (prevd ? wgt(k) : -wgt(k)), "R4",
                    int'(dac_code), prev + (prevd ? wgt(k) : -wgt(k)), "reference step");
            if (mode == 0) begin
                d = pat[M-k];
            end else begin
                diff = vin2 - 2 * int'(dac_code);
                d = (diff > 0);
                if (inject && ((diff < 0) ? -diff : diff) < 2 * tol(k)) d = ~d;
            end
            prev  = int'(dac_code);
            prevd = d;
            cmp_valid = 1'b1;
            cmp_above = d;
            @(negedge clk);
            cmp_valid = 1'b0;
            if (k < M) begin
                chk(!cmp_req && !done, "R3", int'(cmp_req), 0, "settle cycle");
                chk(!done, "R5", int'(done), 0, "no early done");
                if (k == 2 && poke == 1) begin
                    cmp_valid = 1'b1;
                    cmp_above = ~d;
                    @(negedge clk);
                    cmp_valid = 1'b0;
                end else if (k == 2 && poke == 2) begin
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end else begin
                chk(done && !busy, "R5", int'(done), 1, "done after last step");
                res = int'(result);
            end
        end
        @(negedge clk);
        chk(!done, "R5", int'(done), 0, "done single cycle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int res;
        int held;
        repeat (3) @(negedge clk);
        chk(!busy && !cmp_req && !done && result == 0 && dac_code == MID, "R1",
            int'(dac_code), MID, "reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // R3: stray decision while idle
        cmp_valid = 1'b1;
        cmp_above = 1'b1;
        repeat (2) @(negedge clk);
        cmp_valid = 1'b0;
        chk(!busy && !done && dac_code == MID, "R3", int'(dac_code), MID, "idle valid ignored");

        // R6: vector table of decision sequences
        foreach (VEC[i]) begin
            run_conv(0, VEC[i][8:4], 0, 1'b0, 0, res);
            chk(res == int'(VEC[i][3:0]), "R6", res, int'(VEC[i][3:0]), "pattern result");
        end

        // R6: ideal comparator, every code
        for (int x = 0; x < 16; x++) begin
            run_conv(1, '0, 2 * x + 1, 1'b0, 0, res);
            chk(res == x, "R6", res, x, "ideal conversion");
        end

        // R7: wrong decisions within tolerance
        for (int x = 0; x < 16; x++) begin
            run_conv(1, '0, 2 * x + 1, 1'b1, 0, res);
            chk(res == x, "R7", res, x, "corrected conversion");
        end

        // R3: stray valid in settle cycle
        run_conv(0, 5'b10101, 0, 1'b0, 1, res);
        chk(res == 9, "R3", res, 9, "stray valid result");

        // R8: start during conversion
        run_conv(0, 5'b01111, 0, 1'b0, 2, res);
        chk(res == 9, "R8", res, 9, "start while busy");

        // R9: result holds
        held = int'(result);
        repeat (5) @(negedge clk);
        chk(int'(result) == held && !busy, "R9", int'(result), held, "result held");

        summary();
        $finish;
    end

endmodule